// File: doc/BRIEF.md
# Dual-Bank Register File with Exchange

This block is the programmer-visible register storage of an 8-bit processor datapath. Six 8-bit general registers exist twice, as a main copy and an alternate copy. The accumulator and flag registers also exist twice, as a main copy and an alternate copy. Only one copy of each group is visible at any time. Two exchange strobes toggle the visible copy. One strobe serves the general group and the other serves the accumulator/flag group. Each takes effect in a single clock, and no data is moved.

The stack pointer, the program counter and two 16-bit index registers are not banked and exist once only. So do the 8-bit interrupt-vector register and the 8-bit refresh register. The refresh register counts opcode fetches in its low seven bits and holds its top bit. The datapath uses one byte-wide read port, one byte-wide write port, one pair-wide read port and one pair-wide write port. Both read ports are registered and return data one clock after the select is presented.

Top module: `dual_bank_regfile`

## Requirements
- R1: Reset (synchronous, active high) clears every register in both banks, as well as the single-copy registers, to zero. It points both bank selects at the main copy, and after reset both read ports return zero.
- R2: The byte port uses these select codes: 0..5 for the six general registers (G0..G5), 6 for the accumulator, 7 for the flags, 8 for the interrupt vector and 9 for refresh. A byte written with a code is returned by a byte read of that code. The read result appears on the clock edge after the select is presented.
- R3: The pair port uses these select codes: 0 = G0:G1, 1 = G2:G3, 2 = G4:G5, 3 = accumulator:flags, 4 = stack pointer, 5 = program counter, 6 = first index and 7 = second index. For a banked pair, the first-named register is bits 15:8 and the second is bits 7:0. A pair write updates both bytes in the same cycle.
- R4: Each pulse of xchg_gen toggles which copy of G0..G5 is visible. The copy not shown keeps its contents unchanged.
- R5: Each pulse of xchg_acc toggles which copy of the accumulator and flags is visible. This is independent of xchg_gen.
- R6: The stack pointer, the program counter and the index registers are unaffected by either exchange strobe.
- R7: Each cycle with fetch high increments refresh bits 6:0, wrapping from 7F to 00 within those bits, and leaves bit 7 unchanged.
- R8: A byte write to refresh overrides a fetch increment in the same cycle, and a write can set bit 7.
- R9: A read and a write of the same register in the same cycle return the value held before the write.
- R10: When a byte write and a pair write address the same register in one cycle, the byte write wins. The other byte of the pair still takes the value from the pair write.
- R11: A write in the same cycle as an exchange lands in the copy that was visible before the exchange.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd8_sel | input | 4 | Byte read select code |
| rd8_data | output | 8 | Registered byte read data |
| rd16_sel | input | 3 | Pair read select code |
| rd16_data | output | 16 | Registered pair read data |
| wr8_en | input | 1 | Byte write enable |
| wr8_sel | input | 4 | Byte write select code |
| wr8_data | input | 8 | Byte write data |
| wr16_en | input | 1 | Pair write enable |
| wr16_sel | input | 3 | Pair write select code |
| wr16_data | input | 16 | Pair write data |
| xchg_gen | input | 1 | Toggle the visible general bank |
| xchg_acc | input | 1 | Toggle the visible accumulator/flag bank |
| fetch | input | 1 | Opcode fetch strobe for refresh counting |

## Verification
Distinct byte values go into every code. This shows that select decoding does not alias two registers onto one another. Pair writes read back as bytes, and byte writes read back as pairs, which fixes the high/low byte order. Exchange sequences are applied to one group while the other group holds known values, which shows that the two swap controls are independent and that the hidden copy keeps its data. Same-cycle collisions (read with write, byte write with pair write, write with exchange, write with fetch) tell apart orderings that agree whenever only one operation is active.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int NGEN   = 6;
  localparam int SELW   = 4;
  localparam int PSELW  = 3;

  localparam logic [SELW-1:0]  SEL_ACC = 4'd6;
  localparam logic [SELW-1:0]  SEL_FLG = 4'd7;
  localparam logic [SELW-1:0]  SEL_VEC = 4'd8;
  localparam logic [SELW-1:0]  SEL_REF = 4'd9;

  localparam logic [PSELW-1:0] PR_ACC  = 3'd3;
  localparam logic [PSELW-1:0] PR_SP   = 3'd4;
  localparam logic [PSELW-1:0] PR_PC   = 3'd5;
  localparam logic [PSELW-1:0] PR_IX   = 3'd6;
  localparam logic [PSELW-1:0] PR_IY   = 3'd7;
endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int DW   = 8,
  parameter int NREG = 6,
  localparam int IW  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int PW  = (NREG > 2) ? $clog2(NREG / 2) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      xchg,
  input  logic                      w8_en,
  input  logic [IW-1:0]             w8_idx,
  input  logic [DW-1:0]             w8_data,
  input  logic                      w16_en,
  input  logic [PW-1:0]             w16_pair,
  input  logic [2*DW-1:0]           w16_data,
  output logic [NREG-1:0][DW-1:0]   vis,
  output logic                      bank
);
  logic [DW-1:0] mem [2][NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      bank <= 1'b0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NREG; i++)
          mem[b][i] <= '0;
    end else begin
      if (xchg) bank <= ~bank;
      for (int i = 0; i < NREG; i++) begin
        if (w16_en && w16_pair == PW'(i / 2))
          mem[bank][i] <= (i % 2 == 0) ? w16_data[2*DW-1:DW] : w16_data[DW-1:0];
        if (w8_en && w8_idx == IW'(i))
          mem[bank][i] <= w8_data;
      end
    end
  end

  always_comb
    for (int i = 0; i < NREG; i++)
      vis[i] = mem[bank][i];

  // R4 / R5: each strobe flips the select, otherwise it holds
  p_bank_toggle_r4: assert property (@(posedge clk) disable iff (rst)
    xchg |=> bank != $past(bank));
  p_bank_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !xchg |=> $stable(bank));
endmodule

// File: rtl/rf_solo.sv
module rf_solo
  import rf_pkg::*;
#(
  parameter int DW  = 8,
  localparam int AW = 2 * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             w8_en,
  input  logic [SELW-1:0]  w8_sel,
  input  logic [DW-1:0]    w8_data,
  input  logic             w16_en,
  input  logic [PSELW-1:0] w16_sel,
  input  logic [AW-1:0]    w16_data,
  input  logic             fetch,
  output logic [AW-1:0]    sp,
  output logic [AW-1:0]    pc,
  output logic [AW-1:0]    ix,
  output logic [AW-1:0]    iy,
  output logic [DW-1:0]    vec,
  output logic [DW-1:0]    refr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sp <= '0; pc <= '0; ix <= '0; iy <= '0;
      vec <= '0; refr <= '0;
    end else begin
      if (w16_en) begin
        case (w16_sel)
          PR_SP:   sp <= w16_data;
          PR_PC:   pc <= w16_data;
          PR_IX:   ix <= w16_data;
          PR_IY:   iy <= w16_data;
          default: ;
        endcase
      end
      if (w8_en && w8_sel == SEL_VEC) vec <= w8_data;
      if (w8_en && w8_sel == SEL_REF)
        refr <= w8_data;
      else if (fetch)
        refr <= {refr[DW-1], refr[DW-2:0] + {{(DW-2){1'b0}}, 1'b1}};
    end
  end

  p_refresh_step_r7: assert property (@(posedge clk) disable iff (rst)
    fetch && !(w8_en && w8_sel == SEL_REF) |=>
      refr[DW-1] == $past(refr[DW-1]) &&
      refr[DW-2:0] == $past(refr[DW-2:0]) + {{(DW-2){1'b0}}, 1'b1});
  p_refresh_write_r8: assert property (@(posedge clk) disable iff (rst)
    w8_en && w8_sel == SEL_REF |=> refr == $past(w8_data));
  p_pc_load_r3: assert property (@(posedge clk) disable iff (rst)
    w16_en && w16_sel == PR_PC |=> pc == $past(w16_data));
endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
  import rf_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       rd8_sel,
  output logic [DW-1:0]    rd8_data,
  input  logic [2:0]       rd16_sel,
  output logic [2*DW-1:0]  rd16_data,
  input  logic             wr8_en,
  input  logic [3:0]       wr8_sel,
  input  logic [DW-1:0]    wr8_data,
  input  logic             wr16_en,
  input  logic [2:0]       wr16_sel,
  input  logic [2*DW-1:0]  wr16_data,
  input  logic             xchg_gen,
  input  logic             xchg_acc,
  input  logic             fetch
);
  localparam int AW = 2 * DW;

  logic [NGEN-1:0][DW-1:0] gen_vis;
  logic [1:0][DW-1:0]      acc_vis;
  logic                    gen_bank, acc_bank;
  logic [AW-1:0]           sp, pc, ix, iy;
  logic [DW-1:0]           vec, refr;

  logic gen_w8, acc_w8, gen_w16, acc_w16;
  assign gen_w8  = wr8_en && (wr8_sel < SELW'(NGEN));
  assign acc_w8  = wr8_en && (wr8_sel == SEL_ACC || wr8_sel == SEL_FLG);
  assign gen_w16 = wr16_en && (wr16_sel < PR_ACC);
  assign acc_w16 = wr16_en && (wr16_sel == PR_ACC);

  rf_bank #(.DW(DW), .NREG(NGEN)) u_gen (
    .clk(clk), .rst(rst), .xchg(xchg_gen),
    .w8_en(gen_w8), .w8_idx(wr8_sel[2:0]), .w8_data(wr8_data),
    .w16_en(gen_w16), .w16_pair(wr16_sel[1:0]), .w16_data(wr16_data),
    .vis(gen_vis), .bank(gen_bank)
  );

  rf_bank #(.DW(DW), .NREG(2)) u_acc (
    .clk(clk), .rst(rst), .xchg(xchg_acc),
    .w8_en(acc_w8), .w8_idx(wr8_sel[0]), .w8_data(wr8_data),
    .w16_en(acc_w16), .w16_pair(1'b0), .w16_data(wr16_data),
    .vis(acc_vis), .bank(acc_bank)
  );

  rf_solo #(.DW(DW)) u_solo (
    .clk(clk), .rst(rst),
    .w8_en(wr8_en), .w8_sel(wr8_sel), .w8_data(wr8_data),
    .w16_en(wr16_en), .w16_sel(wr16_sel), .w16_data(wr16_data),
    .fetch(fetch),
    .sp(sp), .pc(pc), .ix(ix), .iy(iy), .vec(vec), .refr(refr)
  );

  logic [DW-1:0] rd8_next;
  logic [AW-1:0] rd16_next;

  always_comb begin
    rd8_next = '0;
    if (rd8_sel < SELW'(NGEN)) rd8_next = gen_vis[rd8_sel[2:0]];
    else if (rd8_sel == SEL_ACC) rd8_next = acc_vis[0];
    else if (rd8_sel == SEL_FLG) rd8_next = acc_vis[1];
    else if (rd8_sel == SEL_VEC) rd8_next = vec;
    else if (rd8_sel == SEL_REF) rd8_next = refr;
  end

  always_comb begin
    case (rd16_sel)
      3'd0:    rd16_next = {gen_vis[0], gen_vis[1]};
      3'd1:    rd16_next = {gen_vis[2], gen_vis[3]};
      3'd2:    rd16_next = {gen_vis[4], gen_vis[5]};
      PR_ACC:  rd16_next = {acc_vis[0], acc_vis[1]};
      PR_SP:   rd16_next = sp;
      PR_PC:   rd16_next = pc;
      PR_IX:   rd16_next = ix;
      default: rd16_next = iy;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd8_data  <= '0;
      rd16_data <= '0;
    end else begin
      rd8_data  <= rd8_next;
      rd16_data <= rd16_next;
    end
  end

  p_sp_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (xchg_gen || xchg_acc) && !wr16_en |=> $stable(sp) && $stable(ix) && $stable(iy));
  p_banks_indep_r5: assert property (@(posedge clk) disable iff (rst)
    xchg_acc && !xchg_gen |=> $stable(gen_bank) && acc_bank != $past(acc_bank));
endmodule

// File: tb/tb_dual_bank_regfile.sv
module tb_dual_bank_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rd8_sel;
  logic [7:0]  rd8_data;
  logic [2:0]  rd16_sel;
  logic [15:0] rd16_data;
  logic        wr8_en, wr16_en, xchg_gen, xchg_acc, fetch;
  logic [3:0]  wr8_sel;
  logic [7:0]  wr8_data;
  logic [2:0]  wr16_sel;
  logic [15:0] wr16_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dual_bank_regfile dut (
    .clk(clk), .rst(rst), .rd8_sel(rd8_sel), .rd8_data(rd8_data),
    .rd16_sel(rd16_sel), .rd16_data(rd16_data),
    .wr8_en(wr8_en), .wr8_sel(wr8_sel), .wr8_data(wr8_data),
    .wr16_en(wr16_en), .wr16_sel(wr16_sel), .wr16_data(wr16_data),
    .xchg_gen(xchg_gen), .xchg_acc(xchg_acc), .fetch(fetch)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic put8(input logic [3:0] s, input logic [7:0] d);
    wr8_en = 1; wr8_sel = s; wr8_data = d; tick(); wr8_en = 0;
  endtask

  task automatic put16(input logic [2:0] s, input logic [15:0] d);
    wr16_en = 1; wr16_sel = s; wr16_data = d; tick(); wr16_en = 0;
  endtask

  task automatic exp8(input string req, input logic [3:0] s, input logic [7:0] e);
    rd8_sel = s; tick(); check(req, {8'h00, rd8_data}, {8'h00, e});
  endtask

  task automatic exp16(input string req, input logic [2:0] s, input logic [15:0] e);
    rd16_sel = s; tick(); check(req, rd16_data, e);
  endtask

  task automatic swap(input logic g, input logic a);
    xchg_gen = g; xchg_acc = a; tick(); xchg_gen = 0; xchg_acc = 0;
  endtask

  task automatic t_reset();     // R1
    exp8("R1", 4'd0, 8'h00); exp8("R1", 4'd6, 8'h00);
    exp8("R1", 4'd9, 8'h00); exp16("R1", 3'd5, 16'h0000);
  endtask

  task automatic t_bytes();     // R2
    for (int i = 0; i < 10; i++) put8(4'(i), 8'h31 + 8'(i) * 8'h13);
    for (int i = 0; i < 10; i++) exp8("R2", 4'(i), 8'h31 + 8'(i) * 8'h13);
  endtask

  task automatic t_pairs();     // R3
    put16(3'd0, 16'h1234);
    exp8("R3", 4'd0, 8'h12); exp8("R3", 4'd1, 8'h34);
    put8(4'd4, 8'h5A); put8(4'd5, 8'hC3);
    exp16("R3", 3'd2, 16'h5AC3);
    put16(3'd3, 16'hA5F0);
    exp8("R3", 4'd6, 8'hA5); exp8("R3", 4'd7, 8'hF0);
    put16(3'd5, 16'hBEEF); exp16("R3", 3'd5, 16'hBEEF);
  endtask

  task automatic t_xgen();      // R4
    swap(1, 0);
    exp8("R4", 4'd0, 8'h00);
    put8(4'd0, 8'h77);
    exp8("R5", 4'd6, 8'hA5);
    swap(1, 0); exp8("R4", 4'd0, 8'h12);
    swap(1, 0); exp8("R4", 4'd0, 8'h77);
    swap(1, 0); exp8("R4", 4'd0, 8'h12);
  endtask

  task automatic t_xacc();      // R5
    swap(0, 1);
    exp8("R5", 4'd6, 8'h00); exp8("R5", 4'd0, 8'h12);
    put8(4'd6, 8'h3C);
    swap(0, 1);
    exp8("R5", 4'd6, 8'hA5); exp16("R5", 3'd3, 16'hA5F0);
    swap(0, 1); exp8("R5", 4'd6, 8'h3C); swap(0, 1);
  endtask

  task automatic t_single();    // R6
    put16(3'd4, 16'hCAFE); put16(3'd6, 16'h1357); put16(3'd7, 16'h2468);
    swap(1, 1);
    exp16("R6", 3'd4, 16'hCAFE); exp16("R6", 3'd6, 16'h1357);
    exp16("R6", 3'd7, 16'h2468); exp16("R6", 3'd5, 16'hBEEF);
    swap(1, 1);
  endtask

  task automatic t_refresh();   // R7
    put8(4'd9, 8'hFE);
    fetch = 1; tick(); tick(); tick(); fetch = 0;
    exp8("R7", 4'd9, 8'h81);
    put8(4'd9, 8'h3F);
    fetch = 1; tick(); fetch = 0;
    exp8("R7", 4'd9, 8'h40);
  endtask

  task automatic t_ref_write(); // R8
    fetch = 1; put8(4'd9, 8'h85); fetch = 0;
    exp8("R8", 4'd9, 8'h85);
  endtask

  task automatic t_rdwr();      // R9: code 2 holds 0x57 from R2
    rd8_sel = 4'd2; wr8_en = 1; wr8_sel = 4'd2; wr8_data = 8'h99;
    tick(); wr8_en = 0;
    check("R9", {8'h00, rd8_data}, 16'h0057);
    exp8("R9", 4'd2, 8'h99);
  endtask

  task automatic t_collide();   // R10
    wr16_en = 1; wr16_sel = 3'd1; wr16_data = 16'h1111;
    wr8_en = 1; wr8_sel = 4'd2; wr8_data = 8'h22;
    tick(); wr16_en = 0; wr8_en = 0;
    exp8("R10", 4'd2, 8'h22); exp8("R10", 4'd3, 8'h11);
  endtask

  task automatic t_xwrite();    // R11
    xchg_gen = 1; wr8_en = 1; wr8_sel = 4'd4; wr8_data = 8'h44;
    tick(); xchg_gen = 0; wr8_en = 0;
    exp8("R11", 4'd4, 8'h00);
    swap(1, 0);
    exp8("R11", 4'd4, 8'h44);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1; rd8_sel = 0; rd16_sel = 0; wr8_en = 0; wr8_sel = 0; wr8_data = 0;
    wr16_en = 0; wr16_sel = 0; wr16_data = 0; xchg_gen = 0; xchg_acc = 0; fetch = 0;
    @(negedge clk); tick(); tick();
    rst = 0;
    check("R1", {8'h00, rd8_data}, 16'h0000);
    t_reset(); t_bytes(); t_pairs(); t_xgen(); t_xacc(); t_single();
    t_refresh(); t_ref_write(); t_rdwr(); t_collide(); t_xwrite();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule